// File: doc/BRIEF.md
# Four-Way Instruction Cache Controller

This block sits between an instruction fetch unit and a line-wide memory port. The fetch unit presents a physical address. When the line is present, the controller returns the 64-bit half of the 16-byte line that the address picks. When the line is absent, it raises a line request to memory. While that request is outstanding it holds off further fetches. When memory answers, it installs the line and returns the requested half. The cache is read-only. Each line carries one presence flag, so a line is either empty or holding current instructions.

Two outside agents can remove lines:

- A global command drops every line at once. It serves both the flush and the push commands, because a read-only cache holds nothing that needs writing back.
- A bus watcher reports snooped accesses. A snooped write to a cached line drops that line. A snooped read leaves it alone.

When a fill needs a way, it takes the lowest empty way in the set. When the set is full, it takes the way named by a free-running pseudo-random sequence.

Top module: `icache_ctrl`

## Requirements
- R1: After reset:
  - every line is empty, so the first fetch of any address misses;
  - `fetch_rdy` is 1;
  - `fetch_valid` is 0;
  - `mem_req` is 0.
- R2: A fetch accepted while `fetch_rdy` is 1 that hits a present line gives `fetch_valid`=1 on the next cycle, with no memory request. The data is line bits 63:0 when address bit 3 is 0, and line bits 127:64 when address bit 3 is 1.
- R3: A fetch accepted on a miss raises `mem_req` on the next cycle. `mem_addr` equals the fetch address with bits 3:0 cleared. Both are held unchanged until `mem_ack`.
- R4: While a fill is outstanding, `fetch_rdy` is 0 and any `fetch_req` is ignored. Neither the pending request nor the eventual reply changes.
- R5: A cycle with `mem_req` and `mem_ack` both high installs `mem_line` as a present line. On the next cycle:
  - `fetch_valid` is 1 with the half of `mem_line` selected as in R2;
  - `mem_req` is 0;
  - `fetch_rdy` is 1.
- R6: A fill goes to the lowest-numbered empty way of the indexed set when one exists.
- R7: When all four ways of the set are present, the victim way is the value of a 2-bit sequence at the clock edge that accepts the miss. The sequence runs 0, 1, 3, 2 and repeats. It is 0 at the first edge after reset and advances on every edge.
- R8: A cycle with `inv_all` high makes every line empty.
- R9: A snoop with `snoop_write`=1 whose address matches a present line makes that line empty. A snoop read, or a snoop that matches no present line, changes nothing.
- R10: Address fields are as follows:
  - bits 3:0 are the byte offset within the line;
  - the next log2(SETS) bits select the set;
  - all remaining upper bits form the tag compared on lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Fetch request, taken when fetch_rdy is 1 |
| fetch_addr | input | ADDR_W | Physical fetch address |
| fetch_rdy | output | 1 | Controller can accept a fetch |
| fetch_valid | output | 1 | fetch_data holds a reply this cycle |
| fetch_data | output | HALF_W | Selected half of the line |
| mem_req | output | 1 | Line request to memory |
| mem_addr | output | ADDR_W | Line-aligned request address |
| mem_ack | input | 1 | Memory returns the line this cycle |
| mem_line | input | 2*HALF_W | Whole line from memory |
| inv_all | input | 1 | Empty every line |
| snoop_valid | input | 1 | Snooped bus access present |
| snoop_write | input | 1 | Snooped access is a write |
| snoop_addr | input | ADDR_W | Snooped address |

## Verification
The hardest case to reach from the ports is a fill into a set whose four ways are all present. There the victim depends on where the free-running sequence stands at the exact acceptance edge, and the way chosen is never shown directly.

The bench first fills each set with four tags. It then counts clock edges since reset and drives misses with fill latencies that vary. This sweeps the acceptance edge across all four sequence phases. Afterwards it probes every old tag, and exactly the predicted one must miss.

A snoop write opens a hole in a full set. This forces the empty-way path (R6) to override the random choice.

// File: rtl/icache_pkg.sv
package icache_pkg;

   typedef enum logic [0:0] {
      CTL_IDLE = 1'b0,
      CTL_FILL = 1'b1
   } ctl_state_e;

   // 2-bit sequence visiting 0,1,3,2 and back to 0
   function automatic logic [1:0] seq_next(input logic [1:0] cur);
      return {cur[0], ~cur[1]};
   endfunction

endpackage

// File: rtl/icache_prng.sv
module icache_prng
   import icache_pkg::*;
#(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [SEL_W-1:0] value
);

   if (SEL_W != 2) begin : g_bad_width
      $error("icache_prng: sequence is defined for a 2-bit selector only");
   end

   logic [SEL_W-1:0] state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= '0;
      else        state_q <= seq_next(state_q);
   end

   assign value = state_q;

endmodule

// File: rtl/icache_lookup.sv
module icache_lookup #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 25,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]  way_present,
   input  logic [TAG_W-1:0] way_tag [WAYS],
   input  logic [TAG_W-1:0] probe_tag,
   output logic             hit,
   output logic [WAY_W-1:0] hit_way
);

   logic [WAYS-1:0] match;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = way_present[w] && (way_tag[w] == probe_tag);
   end

   always_comb begin
      hit_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (match[w]) hit_way = WAY_W'(w);
      end
   end

   assign hit = |match;

endmodule

// File: rtl/icache_victim.sv
module icache_victim #(
   parameter int WAYS = 4,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]  way_present,
   input  logic [WAY_W-1:0] random_way,
   output logic [WAY_W-1:0] victim
);

   always_comb begin
      victim = random_way;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!way_present[w]) victim = WAY_W'(w);
      end
   end

endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
   import icache_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SETS   = 8,
   parameter int WAYS   = 4,
   parameter int HALF_W = 64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  fetch_req,
   input  logic [ADDR_W-1:0]     fetch_addr,
   output logic                  fetch_rdy,
   output logic                  fetch_valid,
   output logic [HALF_W-1:0]     fetch_data,
   output logic                  mem_req,
   output logic [ADDR_W-1:0]     mem_addr,
   input  logic                  mem_ack,
   input  logic [2*HALF_W-1:0]   mem_line,
   input  logic                  inv_all,
   input  logic                  snoop_valid,
   input  logic                  snoop_write,
   input  logic [ADDR_W-1:0]     snoop_addr
);

   localparam int LINE_W     = 2 * HALF_W;
   localparam int LINE_BYTES = LINE_W / 8;
   localparam int OFF_W      = $clog2(LINE_BYTES);
   localparam int IDX_W      = $clog2(SETS);
   localparam int TAG_W      = ADDR_W - OFF_W - IDX_W;
   localparam int WAY_W      = $clog2(WAYS);

   if (WAYS != 4) begin : g_bad_ways
      $error("icache_ctrl: replacement sequence covers exactly four ways");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("icache_ctrl: SETS must be a power of two of at least 2");
   end
   if ((HALF_W % 8) != 0 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("icache_ctrl: line must be a power-of-two number of bytes");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("icache_ctrl: address too narrow for offset and index");
   end

   // ---------------- storage ----------------
   logic [WAYS-1:0]   vld_q [SETS];
   logic [WAYS-1:0]   vld_n [SETS];
   logic [TAG_W-1:0]  tag_q [SETS][WAYS];
   logic [LINE_W-1:0] dat_q [SETS][WAYS];

   // ---------------- address fields ----------------
   logic [IDX_W-1:0] f_idx, s_idx;
   logic [TAG_W-1:0] f_tag, s_tag;
   logic             f_half;

   assign f_idx  = fetch_addr[OFF_W +: IDX_W];
   assign f_tag  = fetch_addr[ADDR_W-1 -: TAG_W];
   assign f_half = fetch_addr[OFF_W-1];
   assign s_idx  = snoop_addr[OFF_W +: IDX_W];
   assign s_tag  = snoop_addr[ADDR_W-1 -: TAG_W];

   logic unused_low_bits;
   assign unused_low_bits = ^{fetch_addr[OFF_W-1:0], snoop_addr[OFF_W-1:0]};

   // ---------------- lookups ----------------
   logic [TAG_W-1:0] f_tags [WAYS];
   logic [TAG_W-1:0] s_tags [WAYS];

   always_comb begin
      for (int w = 0; w < WAYS; w++) begin
         f_tags[w] = tag_q[f_idx][w];
         s_tags[w] = tag_q[s_idx][w];
      end
   end

   logic             f_hit, s_hit;
   logic [WAY_W-1:0] f_hit_way, s_hit_way;

   icache_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) i_fetch_lookup (
      .way_present (vld_q[f_idx]),
      .way_tag     (f_tags),
      .probe_tag   (f_tag),
      .hit         (f_hit),
      .hit_way     (f_hit_way)
   );

   icache_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) i_snoop_lookup (
      .way_present (vld_q[s_idx]),
      .way_tag     (s_tags),
      .probe_tag   (s_tag),
      .hit         (s_hit),
      .hit_way     (s_hit_way)
   );

   // ---------------- replacement ----------------
   logic [WAY_W-1:0] rnd_way, victim_way;

   icache_prng #(.SEL_W(WAY_W)) i_prng (
      .clk   (clk),
      .rst_n (rst_n),
      .value (rnd_way)
   );

   icache_victim #(.WAYS(WAYS)) i_victim (
      .way_present (vld_q[f_idx]),
      .random_way  (rnd_way),
      .victim      (victim_way)
   );

   // ---------------- control ----------------
   ctl_state_e        state_q;
   logic              req_q;
   logic              rsp_v_q;
   logic [HALF_W-1:0] rsp_d_q;
   logic [TAG_W-1:0]  fill_tag_q;
   logic [IDX_W-1:0]  fill_idx_q;
   logic [WAY_W-1:0]  fill_way_q;
   logic              fill_half_q;
   logic              fill_done;
   logic [LINE_W-1:0] hit_line;

   assign fill_done = (state_q == CTL_FILL) && mem_ack;
   assign hit_line  = dat_q[f_idx][f_hit_way];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= CTL_IDLE;
         req_q       <= 1'b0;
         rsp_v_q     <= 1'b0;
         rsp_d_q     <= '0;
         fill_tag_q  <= '0;
         fill_idx_q  <= '0;
         fill_way_q  <= '0;
         fill_half_q <= 1'b0;
      end else begin
         rsp_v_q <= 1'b0;
         unique case (state_q)
            CTL_IDLE: begin
               if (fetch_req) begin
                  if (f_hit) begin
                     rsp_v_q <= 1'b1;
                     rsp_d_q <= f_half ? hit_line[LINE_W-1 -: HALF_W]
                                       : hit_line[HALF_W-1:0];
                  end else begin
                     state_q     <= CTL_FILL;
                     req_q       <= 1'b1;
                     fill_tag_q  <= f_tag;
                     fill_idx_q  <= f_idx;
                     fill_way_q  <= victim_way;
                     fill_half_q <= f_half;
                  end
               end
            end
            CTL_FILL: begin
               if (mem_ack) begin
                  state_q <= CTL_IDLE;
                  req_q   <= 1'b0;
                  rsp_v_q <= 1'b1;
                  rsp_d_q <= fill_half_q ? mem_line[LINE_W-1 -: HALF_W]
                                         : mem_line[HALF_W-1:0];
               end
            end
            default: state_q <= CTL_IDLE;
         endcase
      end
   end

   // presence flags: fill sets, snoop write clears, global drop wins
   always_comb begin
      for (int s = 0; s < SETS; s++) vld_n[s] = vld_q[s];
      if (fill_done) vld_n[fill_idx_q][fill_way_q] = 1'b1;
      if (snoop_valid && snoop_write && s_hit) vld_n[s_idx][s_hit_way] = 1'b0;
      if (inv_all) begin
         for (int s = 0; s < SETS; s++) vld_n[s] = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      end else begin
         for (int s = 0; s < SETS; s++) vld_q[s] <= vld_n[s];
      end
   end

   always_ff @(posedge clk) begin
      if (fill_done) begin
         tag_q[fill_idx_q][fill_way_q] <= fill_tag_q;
         dat_q[fill_idx_q][fill_way_q] <= mem_line;
      end
   end

   assign fetch_rdy   = (state_q == CTL_IDLE);
   assign fetch_valid = rsp_v_q;
   assign fetch_data  = rsp_d_q;
   assign mem_req     = req_q;
   assign mem_addr    = {fill_tag_q, fill_idx_q, {OFF_W{1'b0}}};

endmodule

// File: rtl/icache_ctrl_chk.sv
module icache_ctrl_chk #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fetch_req,
   input logic              fetch_rdy,
   input logic              fetch_valid,
   input logic              mem_req,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              lookup_hit
);

   p_fill_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !fetch_rdy);

   p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   p_line_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[OFF_W-1:0] == '0));

   p_miss_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && fetch_rdy && !lookup_hit) |=> mem_req);

   p_hit_reply_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && fetch_rdy && lookup_hit) |=> (fetch_valid && !mem_req));

   p_fill_reply_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack) |=> (fetch_valid && fetch_rdy && !mem_req));

endmodule

bind icache_ctrl icache_ctrl_chk #(
   .ADDR_W (ADDR_W),
   .OFF_W  (OFF_W)
) i_icache_ctrl_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fetch_req   (fetch_req),
   .fetch_rdy   (fetch_rdy),
   .fetch_valid (fetch_valid),
   .mem_req     (mem_req),
   .mem_ack     (mem_ack),
   .mem_addr    (mem_addr),
   .lookup_hit  (f_hit)
);

// File: tb/test_icache_ctrl.sv
`timescale 1ns/1ps
module test_icache_ctrl;

   localparam int ADDR_W = 32;
   localparam int SETS   = 8;
   localparam int WAYS   = 4;
   localparam int HALF_W = 64;
   localparam int TAG_W  = 25;

   logic               clk, rst_n;
   logic               fetch_req, fetch_rdy, fetch_valid;
   logic [ADDR_W-1:0]  fetch_addr;
   logic [HALF_W-1:0]  fetch_data;
   logic               mem_req, mem_ack;
   logic [ADDR_W-1:0]  mem_addr;
   logic [127:0]       mem_line;
   logic               inv_all, snoop_valid, snoop_write;
   logic [ADDR_W-1:0]  snoop_addr;

   icache_ctrl #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .HALF_W(HALF_W)) i_icache_ctrl (
      .clk(clk), .rst_n(rst_n),
      .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_rdy(fetch_rdy),
      .fetch_valid(fetch_valid), .fetch_data(fetch_data),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_line(mem_line),
      .inv_all(inv_all), .snoop_valid(snoop_valid), .snoop_write(snoop_write),
      .snoop_addr(snoop_addr)
   );

   initial begin
      clk = 1'b0;
      forever #2.5 clk = ~clk;
   end

   int n_chk = 0;
   int n_bad = 0;
   int edges = 0;

   always @(posedge clk) if (rst_n) edges <= edges + 1;

   // bench view of the cache contents
   logic [TAG_W-1:0] m_tag [SETS][WAYS];
   bit               m_vld [SETS][WAYS];

   function automatic logic [127:0] line_of(input logic [31:0] la);
      return {la ^ 32'hA5A5_0F0F, la * 32'd3 + 32'd1, ~la, la + 32'h1234_5678};
   endfunction

   function automatic logic [31:0] mk_addr(input int tag, input int idx, input bit half);
      logic [31:0] t = tag;
      logic [31:0] i = idx;
      return {t[24:0], i[2:0], half, 3'b000};
   endfunction

   task automatic check(input bit ok, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic fetch(input logic [31:0] a, input int lat, input string lbl);
      int idx = int'(a[6:4]);
      logic [TAG_W-1:0] tag = a[31:7];
      logic [31:0] la = {4'b0, a[31:4]};
      logic [127:0] ln = line_of(la);
      logic [63:0] exp_d = a[3] ? ln[127:64] : ln[63:0];
      bit hit = 0;
      int vic = -1;
      int seqv;
      @(negedge clk);
      for (int w = 0; w < WAYS; w++) if (m_vld[idx][w] && m_tag[idx][w] == tag) hit = 1;
      case (edges % 4)
         0: seqv = 0;
         1: seqv = 1;
         2: seqv = 3;
         default: seqv = 2;
      endcase
      for (int w = WAYS - 1; w >= 0; w--) if (!m_vld[idx][w]) vic = w;
      if (vic < 0) vic = seqv;
      fetch_req = 1'b1;
      fetch_addr = a;
      @(negedge clk);
      fetch_req = 1'b0;
      if (hit) begin
         check(fetch_valid == 1'b1, {lbl, " R2 hit valid"}, 128'(fetch_valid), 128'(1));
         check(fetch_data == exp_d, {lbl, " R2 hit half data"}, 128'(fetch_data), 128'(exp_d));
         check(mem_req == 1'b0, {lbl, " R2 hit no mem_req"}, 128'(mem_req), 128'(0));
      end else begin
         check(mem_req == 1'b1 && fetch_valid == 1'b0, {lbl, " R3 miss raises mem_req"},
               128'({mem_req, fetch_valid}), 128'(2'b10));
         check(mem_addr == {a[31:4], 4'b0}, {lbl, " R3 R10 line address"},
               128'(mem_addr), 128'({a[31:4], 4'b0}));
         for (int k = 0; k < lat; k++) begin
            fetch_req = 1'b1;
            fetch_addr = a ^ 32'h0000_0098;
            @(negedge clk);
            check(fetch_rdy == 1'b0 && mem_req == 1'b1 && mem_addr == {a[31:4], 4'b0},
                  {lbl, " R4 stall ignores fetch"}, 128'({fetch_rdy, mem_req, mem_addr}),
                  128'({1'b0, 1'b1, a[31:4], 4'b0}));
         end
         fetch_req = 1'b0;
         mem_ack = 1'b1;
         mem_line = ln;
         @(negedge clk);
         mem_ack = 1'b0;
         mem_line = '0;
         check(fetch_valid == 1'b1 && fetch_data == exp_d, {lbl, " R5 fill reply data"},
               128'(fetch_data), 128'(exp_d));
         check(fetch_rdy == 1'b1 && mem_req == 1'b0, {lbl, " R5 ready after fill"},
               128'({fetch_rdy, mem_req}), 128'(2'b10));
         m_tag[idx][vic] = tag;
         m_vld[idx][vic] = 1'b1;
      end
   endtask

   task automatic snoop(input logic [31:0] a, input bit wr);
      int idx = int'(a[6:4]);
      logic [TAG_W-1:0] tag = a[31:7];
      @(negedge clk);
      snoop_valid = 1'b1;
      snoop_write = wr;
      snoop_addr = a;
      @(negedge clk);
      snoop_valid = 1'b0;
      snoop_write = 1'b0;
      if (wr) for (int w = 0; w < WAYS; w++)
         if (m_vld[idx][w] && m_tag[idx][w] == tag) m_vld[idx][w] = 1'b0;
   endtask

   task automatic drop_all();
      @(negedge clk);
      inv_all = 1'b1;
      @(negedge clk);
      inv_all = 1'b0;
      for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) m_vld[s][w] = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] lcg = 32'h1;
      rst_n = 1'b0;
      fetch_req = 1'b0; fetch_addr = '0; mem_ack = 1'b0; mem_line = '0;
      inv_all = 1'b0; snoop_valid = 1'b0; snoop_write = 1'b0; snoop_addr = '0;
      for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) begin
         m_vld[s][w] = 1'b0;
         m_tag[s][w] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(fetch_rdy == 1'b1 && fetch_valid == 1'b0 && mem_req == 1'b0, "R1 reset outputs",
            128'({fetch_rdy, fetch_valid, mem_req}), 128'(3'b100));

      // R1 R6 R10: fill every set with four tags, all misses, lowest empty way first
      for (int s = 0; s < SETS; s++)
         for (int t = 0; t < WAYS; t++) fetch(mk_addr(t + 4 * s, s, t[0]), t % 3, "R1 R6");
      // R2 R10: both halves of every line hit
      for (int s = 0; s < SETS; s++)
         for (int t = 0; t < WAYS; t++) begin
            fetch(mk_addr(t + 4 * s, s, 1'b0), 0, "R2 R10");
            fetch(mk_addr(t + 4 * s, s, 1'b1), 0, "R2 R10");
         end

      // R7: full sets, new tags at varying phases, then probe old tags
      for (int s = 0; s < SETS; s++) begin
         fetch(mk_addr(100 + s, s, 1'b0), s % 4, "R7");
         for (int t = 0; t < WAYS; t++) fetch(mk_addr(t + 4 * s, s, 1'b1), 1, "R7 probe");
      end

      // R6: snoop write opens a hole, next fill must land there
      snoop(mk_addr(m_tag[2][2], 2, 1'b0), 1'b1);
      fetch(mk_addr(200, 2, 1'b0), 2, "R9 R6");
      for (int w = 0; w < WAYS; w++) fetch(mk_addr(int'(m_tag[2][w]), 2, 1'b1), 0, "R6 survivors");

      // R9: snoop read and snoop miss change nothing; snoop write drops the line
      snoop(mk_addr(m_tag[3][1], 3, 1'b0), 1'b0);
      snoop(mk_addr(777, 3, 1'b0), 1'b1);
      for (int w = 0; w < WAYS; w++) fetch(mk_addr(int'(m_tag[3][w]), 3, 1'b0), 0, "R9 no effect");
      snoop(mk_addr(m_tag[3][0], 3, 1'b1), 1'b1);
      fetch(mk_addr(int'(m_tag[4][0]), 4, 1'b0), 0, "R9 other set kept");
      for (int w = 0; w < WAYS; w++) fetch(mk_addr(int'(m_tag[3][w]), 3, 1'b0), 1, "R9 after write");

      // R8: global drop, every set misses again
      drop_all();
      for (int s = 0; s < SETS; s++) fetch(mk_addr(int'(m_tag[s][1]), s, 1'b1), 1, "R8");

      // mixed sweep over a small tag space
      for (int n = 0; n < 500; n++) begin
         lcg = lcg * 32'd1103515245 + 32'd12345;
         if (lcg[29:25] == 5'd0) drop_all();
         else if (lcg[28:26] == 3'd1)
            snoop(mk_addr(int'(lcg[20:18]), int'(lcg[10:8]), 1'b0), lcg[30]);
         fetch(mk_addr(int'(lcg[20:18]), int'(lcg[10:8]), lcg[5]), int'(lcg[13:12]), "R7 R9 sweep");
      end

      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule